// File: doc/BRIEF.md
# Per-Bit Pattern Match Detector

This block watches an input port, eight bits wide by default, and raises a sticky match flag when the port satisfies a programmed pattern. Three configuration vectors set the condition for each bit: mask, transition and polarity. Together they give each bit one of six conditions: ignored, any change, low level, high level, falling edge or rising edge. A two-bit mode selects how the per-bit results combine. The modes are off, AND over the bits that take part, plain OR, and OR with a priority encoder that reports the highest-numbered bit that hit.

Edges are found by comparing the present port value with the value registered on the previous clock. The detector stays idle for the first clock after reset. This keeps the reset value of the history register from producing a false edge.

When a match is detected and the flag is clear, the flag sets and the priority index is recorded. If latch-on-match is enabled, the port value is also captured. The flag and the captured values then hold until a one-cycle clear pulse arrives.

Top module: `pm_detect`

## Requirements
- R1: After reset, `match_flag`, `match_idx` and `latched_data` are all zero.
- R2: A bit whose mask and transition bits are both 0 never causes a match, whatever its polarity bit and port value.
- R3: A bit with mask 0 and transition 1 matches in any cycle where its port value differs from the value one clock earlier.
- R4: A bit with mask 1 and transition 0 matches while its port value equals its polarity bit: 0 selects low level, 1 selects high level.
- R5: A bit with mask 1 and transition 1 matches on a 1-to-0 change when its polarity is 0, and on a 0-to-1 change when its polarity is 1. A change in the other direction does not match.
- R6: `cfg_mode` is encoded as follows: 0 = matching off (no match ever), 1 = AND, 2 = OR, 3 = priority OR.
- R7: In AND mode a match needs every bit that takes part (any bit not set to "ignored") to be satisfied. If no bit takes part, there is no match.
- R8: In priority OR mode, `match_idx` is set to the index of the highest-numbered satisfied bit when the flag sets. In the other modes it is set to 0.
- R9: `match_flag` sets in the clock after a match and stays set until `clr_flag` is high at a clock edge. A match in that same cycle keeps it set.
- R10: When latch-on-match is enabled and the flag sets, `latched_data` takes the port value of the matching cycle. While the flag is set, the value does not change. With the option disabled, it keeps its old value.
- R11: No match is reported from the first clock edge after reset. This holds even if the port value differs from the all-zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_in | input | W | Watched input port |
| cfg_mask | input | W | Per-bit mask vector |
| cfg_trans | input | W | Per-bit transition vector |
| cfg_pol | input | W | Per-bit polarity vector |
| cfg_mode | input | 2 | Combining rule (0 off, 1 AND, 2 OR, 3 priority OR) |
| cfg_latch | input | 1 | Capture port value when flag sets |
| clr_flag | input | 1 | One-cycle clear of the sticky flag |
| match_flag | output | 1 | Sticky match flag |
| match_idx | output | $clog2(W) | Recorded priority index |
| latched_data | output | W | Port value captured on match |

## Verification
The bench drives edges in both directions against each edge setting. A design with the polarity sense swapped would flag the wrong direction, and one that compared levels would flag a steady port. It checks AND mode with every bit ignored, where a naive reduction over all bits would report a spurious match. It also checks priority OR with several bits hit, where a low-first encoder would report the wrong index. Other cases cover a clear that coincides with a fresh match, data changing under a set flag, and a nonzero port on the first cycle after reset. A wrong design would drop the flag, overwrite the captured value, or report a false edge against the reset history.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        PM_OFF  = 2'd0,
        PM_AND  = 2'd1,
        PM_OR   = 2'd2,
        PM_PRIO = 2'd3
    } pm_mode_e;

endpackage

// File: rtl/pm_bit_eval.sv
module pm_bit_eval #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port_in,
    input  logic [W-1:0] cfg_mask,
    input  logic [W-1:0] cfg_trans,
    input  logic [W-1:0] cfg_pol,
    output logic [W-1:0] hit,
    output logic [W-1:0] care
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         armed;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = port_in;
        st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic rise_b, fall_b, lvl_b, raw_b;

        always_comb begin
            rise_b = port_in[b] & ~st_q.prev[b];
            fall_b = ~port_in[b] & st_q.prev[b];
            lvl_b  = ~(port_in[b] ^ cfg_pol[b]);
            unique case ({cfg_mask[b], cfg_trans[b]})
                2'b00:   raw_b = 1'b0;
                2'b01:   raw_b = rise_b | fall_b;
                2'b10:   raw_b = lvl_b;
                default: raw_b = cfg_pol[b] ? rise_b : fall_b;
            endcase
            hit[b]  = raw_b & st_q.armed;
            care[b] = cfg_mask[b] | cfg_trans[b];
        end

        // R2: an ignored bit never reports a hit
        a_r2_ignored_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_mask[b] && !cfg_trans[b]) |-> !hit[b]);
    end

    // R11: nothing hits before the history register holds a real sample
    a_r11_idle_first: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |-> (hit == '0));

endmodule

// File: rtl/pm_combine.sv
module pm_combine
    import pm_pkg::*;
#(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pm_mode_e         mode,
    input  logic [W-1:0]     hit,
    input  logic [W-1:0]     care,
    output logic             match,
    output logic [IDX_W-1:0] idx
);

    logic             all_ok;
    logic             any_hit;
    logic             any_care;
    logic [IDX_W-1:0] top_idx;

    always_comb begin
        all_ok   = &(hit | ~care);
        any_hit  = |hit;
        any_care = |care;
        top_idx  = '0;
        for (int i = 0; i < W; i++) begin
            if (hit[i]) top_idx = i[IDX_W-1:0];
        end
    end

    always_comb begin
        match = 1'b0;
        idx   = '0;
        unique case (mode)
            PM_OFF:  match = 1'b0;
            PM_AND:  match = all_ok & any_care;
            PM_OR:   match = any_hit;
            PM_PRIO: begin
                match = any_hit;
                idx   = top_idx;
            end
            default: match = 1'b0;
        endcase
    end

    // R6: mode 0 silences the detector
    a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_OFF) |-> !match);

    // R7: AND with nothing taking part never matches
    a_r7_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_AND && care == '0) |-> !match);

    // R8: reported priority index points at a bit that hit
    a_r8_prio_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PRIO && match) |-> hit[idx]);

endmodule

// File: rtl/pm_capture.sv
module pm_capture #(
    parameter int W     = 8,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     port_in,
    input  logic             cfg_latch,
    input  logic             clr_flag,
    output logic             flag,
    output logic [IDX_W-1:0] idx_out,
    output logic [W-1:0]     data_out
);

    typedef struct packed {
        logic             flag;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     data;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (match && !st_q.flag) begin
            st_d.idx = idx;
            if (cfg_latch) st_d.data = port_in;
        end
        st_d.flag = match | (st_q.flag & ~clr_flag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag     = st_q.flag;
    assign idx_out  = st_q.idx;
    assign data_out = st_q.data;

    // R9: flag holds without a clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr_flag) |=> st_q.flag);

    // R9: a match always leaves the flag set
    a_r9_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.flag);

    // R10: captured data frozen while the flag is set
    a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |=> $stable(st_q.data));

endmodule

// File: rtl/pm_detect.sv
module pm_detect
    import pm_pkg::*;
#(
    parameter int W = 8,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     port_in,
    input  logic [W-1:0]     cfg_mask,
    input  logic [W-1:0]     cfg_trans,
    input  logic [W-1:0]     cfg_pol,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_latch,
    input  logic             clr_flag,
    output logic             match_flag,
    output logic [IDX_W-1:0] match_idx,
    output logic [W-1:0]     latched_data
);

    logic [W-1:0]     hit_w;
    logic [W-1:0]     care_w;
    logic             match_w;
    logic [IDX_W-1:0] idx_w;
    pm_mode_e         mode_w;

    assign mode_w = pm_mode_e'(cfg_mode);

    pm_bit_eval #(.W(W)) eval_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_in   (port_in),
        .cfg_mask  (cfg_mask),
        .cfg_trans (cfg_trans),
        .cfg_pol   (cfg_pol),
        .hit       (hit_w),
        .care      (care_w)
    );

    pm_combine #(.W(W), .IDX_W(IDX_W)) comb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_w),
        .hit   (hit_w),
        .care  (care_w),
        .match (match_w),
        .idx   (idx_w)
    );

    pm_capture #(.W(W), .IDX_W(IDX_W)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match_w),
        .idx       (idx_w),
        .port_in   (port_in),
        .cfg_latch (cfg_latch),
        .clr_flag  (clr_flag),
        .flag      (match_flag),
        .idx_out   (match_idx),
        .data_out  (latched_data)
    );

endmodule

// File: tb/pm_detect_tb_top.sv
module pm_detect_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] port_in = '0;
    logic [W-1:0] cfg_mask = '0;
    logic [W-1:0] cfg_trans = '0;
    logic [W-1:0] cfg_pol = '0;
    logic [1:0]   cfg_mode = 2'd0;
    logic         cfg_latch = 1'b0;
    logic         clr_flag = 1'b0;
    logic         match_flag;
    logic [2:0]   match_idx;
    logic [W-1:0] latched_data;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pm_detect #(.W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_in      (port_in),
        .cfg_mask     (cfg_mask),
        .cfg_trans    (cfg_trans),
        .cfg_pol      (cfg_pol),
        .cfg_mode     (cfg_mode),
        .cfg_latch    (cfg_latch),
        .clr_flag     (clr_flag),
        .match_flag   (match_flag),
        .match_idx    (match_idx),
        .latched_data (latched_data)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(logic [W-1:0] v);
        port_in = v;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(logic [W-1:0] m, logic [W-1:0] t, logic [W-1:0] p, logic [1:0] md);
        cfg_mask  = m;
        cfg_trans = t;
        cfg_pol   = p;
        cfg_mode  = md;
    endtask

    task automatic clear_flag();
        cfg_mode = 2'd0;
        clr_flag = 1'b1;
        @(posedge clk);
        #1;
        clr_flag = 1'b0;
        chk("R9 clear drops flag", match_flag, 0);
    endtask

    task automatic t_reset_and_first();
        cfg(8'h00, 8'h01, 8'h00, 2'd2);
        port_in = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 flag", match_flag, 0);
        chk("R1 idx", match_idx, 0);
        chk("R1 data", latched_data, 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R11 first cycle idle", match_flag, 0);
        step(8'hFF);
        chk("R11 steady after first", match_flag, 0);
    endtask

    task automatic t_ignored();
        clear_flag();
        cfg(8'h00, 8'h00, 8'hFF, 2'd2);
        step(8'h00);
        step(8'hFF);
        step(8'h55);
        chk("R2 ignored bits under OR", match_flag, 0);
        cfg_mode = 2'd3;
        step(8'hAA);
        chk("R2 ignored bits under priority", match_flag, 0);
    endtask

    task automatic t_any_change();
        clear_flag();
        step(8'h00);
        cfg(8'h00, 8'h01, 8'h00, 2'd2);
        step(8'h00);
        chk("R3 no change", match_flag, 0);
        step(8'h01);
        chk("R3 rising change", match_flag, 1);
        clear_flag();
        cfg_mode = 2'd2;
        step(8'h00);
        chk("R3 falling change", match_flag, 1);
    endtask

    task automatic t_level();
        clear_flag();
        cfg(8'h01, 8'h00, 8'h00, 2'd2);
        step(8'hFE);
        chk("R4 low level", match_flag, 1);
        clear_flag();
        cfg(8'h01, 8'h00, 8'h01, 2'd2);
        step(8'h00);
        chk("R4 high level not met", match_flag, 0);
        step(8'h01);
        chk("R4 high level met", match_flag, 1);
    endtask

    task automatic t_edges();
        clear_flag();
        step(8'h01);
        cfg(8'h01, 8'h01, 8'h01, 2'd2);
        step(8'h00);
        chk("R5 falling ignored by rise setting", match_flag, 0);
        step(8'h00);
        chk("R5 steady low", match_flag, 0);
        step(8'h01);
        chk("R5 rising edge", match_flag, 1);
        clear_flag();
        cfg(8'h01, 8'h01, 8'h00, 2'd2);
        step(8'h01);
        chk("R5 steady high", match_flag, 0);
        step(8'h00);
        chk("R5 falling edge", match_flag, 1);
        clear_flag();
        cfg(8'h01, 8'h01, 8'h00, 2'd2);
        step(8'h01);
        chk("R5 rising ignored by fall setting", match_flag, 0);
    endtask

    task automatic t_and_off();
        clear_flag();
        cfg(8'h03, 8'h00, 8'h03, 2'd1);
        step(8'h01);
        chk("R7 partial AND", match_flag, 0);
        step(8'h03);
        chk("R7 full AND", match_flag, 1);
        clear_flag();
        cfg(8'h03, 8'h00, 8'h03, 2'd0);
        step(8'h03);
        chk("R6 mode off", match_flag, 0);
        cfg(8'h00, 8'h00, 8'h00, 2'd1);
        step(8'hFF);
        chk("R7 AND all ignored", match_flag, 0);
        cfg(8'h03, 8'h00, 8'h03, 2'd2);
        step(8'h02);
        chk("R6 mode OR one bit", match_flag, 1);
        chk("R8 idx zero outside priority", match_idx, 0);
    endtask

    task automatic t_prio();
        clear_flag();
        cfg(8'hFF, 8'h00, 8'hFF, 2'd3);
        step(8'h24);
        chk("R8 flag", match_flag, 1);
        chk("R8 idx highest of 2,5", match_idx, 5);
        clear_flag();
        cfg_mode = 2'd3;
        step(8'h81);
        chk("R8 idx highest of 0,7", match_idx, 7);
    endtask

    task automatic t_sticky();
        clear_flag();
        cfg(8'h01, 8'h00, 8'h01, 2'd2);
        step(8'h01);
        chk("R9 set", match_flag, 1);
        step(8'h00);
        step(8'h00);
        chk("R9 held after condition gone", match_flag, 1);
        port_in  = 8'h01;
        clr_flag = 1'b1;
        @(posedge clk);
        #1;
        clr_flag = 1'b0;
        chk("R9 match beats clear", match_flag, 1);
    endtask

    task automatic t_latch();
        clear_flag();
        cfg_latch = 1'b1;
        cfg(8'h01, 8'h00, 8'h01, 2'd2);
        step(8'hA5);
        chk("R10 flag", match_flag, 1);
        chk("R10 captured", latched_data, 8'hA5);
        step(8'hB7);
        chk("R10 held while flag set", latched_data, 8'hA5);
        clear_flag();
        cfg_latch = 1'b0;
        cfg_mode = 2'd2;
        step(8'hC3);
        chk("R10 latch off flag", match_flag, 1);
        chk("R10 latch off keeps data", latched_data, 8'hA5);
    endtask

    initial begin
        t_reset_and_first();
        t_ignored();
        t_any_change();
        t_level();
        t_edges();
        t_and_off();
        t_prio();
        t_sticky();
        t_latch();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule